// File: doc/BRIEF.md
# Receive Frame Queue with Word Readout

This block sits behind the receive side of an Ethernet MAC. It takes incoming frames as a byte stream marked by an end-of-frame flag and keeps up to 31 of them in a circular set of slots. It stores each frame as a self-describing record: a 16-bit length, the payload, the CRC-32 computed while the bytes arrive, and zero padding up to a 32-bit boundary.

A host empties the queue through one 32-bit data port. Each read strobe returns the next word of the oldest record. When the last word of a record has been read, the block moves to the next record on its own. The block reports how many records are waiting. It keeps two sticky flags: one for a stored frame and one for a frame dropped because it was too long. A reset command empties the queue at once.

The queue's size is set by `SLOTS`, and the bytes per slot by `SLOT_BYTES`. A full-size build uses 2048 bytes per slot. The default is smaller so that the storage stays modest.

Top module: `rxq_frame_queue`

## Requirements
- R1: A frame whose first byte is accepted while `rx_en` is low is consumed and discarded: `pending` and both flags stay unchanged.
- R2: At most `SLOTS` (31) records are held. When `pending` equals `SLOTS` and `rx_en` is high, `in_ready` is low before the first byte of a frame.
- R3: A frame with a payload of `SLOT_BYTES-6` bytes or more (2042 with 2048-byte slots) is not stored, and `flag_ovf` becomes 1. A payload one byte shorter is stored.
- R4: A stored record is laid out as follows. Bytes 0 and 1 hold payload size + 6, least significant byte first. The payload starts at byte 2. The four CRC bytes follow the payload, least significant byte first. Any bytes left in the final 32-bit word read as zero.
- R5: Storing a record sets `flag_rx` and raises `pending` by one.
- R6: A read strobe while `pending` is non-zero returns four consecutive record bytes. The lower byte address sits in bits 7:0. The read position then moves on by four bytes.
- R7: When the read position reaches or passes the stored length, it returns to 0, the oldest slot index advances (wrapping from `SLOTS-1` to 0), and `pending` drops by one.
- R8: A read strobe while `pending` is zero returns 0 and changes no state.
- R9: A `fifo_rst` pulse clears `pending` and the read position. The next stored frame is then read from its first word.
- R10: The CRC field is the reflected CRC-32 (polynomial 0xEDB88320) of the payload bytes, starting from all ones and inverted at the end.
- R11: The flags are sticky. `flag_ack[0]` clears `flag_rx` and `flag_ack[1]` clears `flag_ovf`. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at each frame's first byte |
| fifo_rst | input | 1 | One-cycle command that empties the queue |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block accepts the byte this cycle |
| rd_strobe | input | 1 | Host read of one data word |
| rd_data | output | 32 | Data word, valid in the strobe cycle |
| pending | output | 5 | Number of complete records waiting |
| flag_ack | input | 2 | Clear strobes for `flag_rx` (bit 0) and `flag_ovf` (bit 1) |
| flag_rx | output | 1 | Sticky: a record was stored |
| flag_ovf | output | 1 | Sticky: an overlong frame was dropped |

## Verification
The assertions assume three things. First, `in_last` closes every frame. Second, `fifo_rst` is never pulsed while a frame is still entering. Third, the host reads only words that belong to a stored record or strobes while the queue is empty. The stimulus always completes a frame before it issues a reset or a read. It pulses `fifo_rst` only between frames, after the trailer has been written. It derives every read count from the record length, which it computes itself. Under these conditions the pending count can never exceed the slot count at a commit, so the full-queue properties rest on that ordering.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    W_IDLE,
    W_BODY,
    W_DROP,
    W_TRAIL,
    W_LEN
  } wr_state_e;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // (a + b) modulo n, for a < n and b <= n
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // word index of a byte position within a slot
  function automatic int unsigned word_index(int unsigned slot, int unsigned bytepos,
                                             int unsigned slot_words);
    return slot * slot_words + bytepos / 4;
  endfunction

  // stored record length for a payload size
  function automatic int unsigned record_len(int unsigned payload);
    return payload + 6;
  endfunction

endpackage

// File: rtl/rxq_crc.sv
module rxq_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  import rxq_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (start) begin
      crc_q <= crc32_step(32'hFFFF_FFFF, din);
    end else if (step) begin
      crc_q <= crc32_step(crc_q, din);
    end
  end

  assign crc_out = ~crc_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 1984,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [31:0]   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_b
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < 4; l++) begin
        if (be[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer #(
  parameter int unsigned SLOTS      = 31,
  parameter int unsigned SLOT_BYTES = 256,
  localparam int unsigned IW   = $clog2(SLOTS),
  localparam int unsigned SW   = SLOT_BYTES / 4,
  localparam int unsigned WAW  = $clog2(SLOTS * SW),
  localparam int unsigned BW   = $clog2(SLOT_BYTES),
  localparam int unsigned MAXP = SLOT_BYTES - 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic           full,
  input  logic [IW-1:0]  tail_slot,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  output logic           in_ready,
  input  logic [31:0]    crc_val,
  output logic           crc_start,
  output logic           crc_step,
  output logic           wr_en,
  output logic [WAW-1:0] wr_addr,
  output logic [3:0]     wr_be,
  output logic [31:0]    wr_data,
  output logic           evt_commit,
  output logic           evt_overrun
);
  import rxq_pkg::*;

  wr_state_e      st_q;
  logic [IW-1:0]  slot_q;
  logic [BW-1:0]  cnt_q;
  logic [BW-1:0]  wpos_q;
  logic [2:0]     tk_q;
  logic           take;
  logic [BW-1:0]  cnt_n;
  logic [BW:0]    body_pos;
  logic [7:0]     trail_byte;

  always_comb begin
    unique case (st_q)
      W_IDLE:         in_ready = !full || !rx_en;
      W_BODY, W_DROP: in_ready = 1'b1;
      default:        in_ready = 1'b0;
    endcase
  end

  assign take       = in_valid && in_ready;
  assign cnt_n      = (32'(cnt_q) < MAXP) ? cnt_q + 1'b1 : cnt_q;
  assign body_pos   = {1'b0, cnt_q} + (BW+1)'(2);
  assign trail_byte = (tk_q < 3'd4) ? crc_val[8*tk_q[1:0] +: 8] : 8'h00;
  assign crc_start  = (st_q == W_IDLE) && take && rx_en;
  assign crc_step   = (st_q == W_BODY) && take;

  always_comb begin
    wr_en       = 1'b0;
    wr_addr     = '0;
    wr_be       = 4'b0000;
    wr_data     = '0;
    evt_commit  = 1'b0;
    evt_overrun = 1'b0;
    unique case (st_q)
      W_IDLE: if (take && rx_en) begin
        wr_en   = 1'b1;
        wr_addr = WAW'(word_index(32'(tail_slot), 2, SW));
        wr_be   = 4'b0100;
        wr_data = {4{in_data}};
      end
      W_BODY: begin
        if (take && 32'(cnt_q) < MAXP) begin
          wr_en   = 1'b1;
          wr_addr = WAW'(word_index(32'(slot_q), 32'(body_pos), SW));
          wr_be   = 4'b0001 << body_pos[1:0];
          wr_data = {4{in_data}};
        end
        evt_overrun = take && in_last && (32'(cnt_n) >= MAXP);
      end
      W_TRAIL: begin
        wr_en   = 1'b1;
        wr_addr = WAW'(word_index(32'(slot_q), 32'(wpos_q), SW));
        wr_be   = 4'b0001 << wpos_q[1:0];
        wr_data = {4{trail_byte}};
      end
      W_LEN: begin
        wr_en      = 1'b1;
        wr_addr    = WAW'(word_index(32'(slot_q), 0, SW));
        wr_be      = 4'b0011;
        wr_data    = {16'd0, 16'(record_len(32'(cnt_q)))};
        evt_commit = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      slot_q <= '0;
      cnt_q  <= '0;
      wpos_q <= '0;
      tk_q   <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (take) begin
          if (!rx_en) begin
            st_q <= in_last ? W_IDLE : W_DROP;
          end else begin
            slot_q <= tail_slot;
            cnt_q  <= BW'(1);
            wpos_q <= BW'(3);
            tk_q   <= '0;
            st_q   <= in_last ? W_TRAIL : W_BODY;
          end
        end
        W_BODY: if (take) begin
          cnt_q <= cnt_n;
          if (in_last) begin
            wpos_q <= cnt_n + BW'(2);
            tk_q   <= '0;
            st_q   <= (32'(cnt_n) >= MAXP) ? W_IDLE : W_TRAIL;
          end
        end
        W_DROP: if (take && in_last) st_q <= W_IDLE;
        W_TRAIL: begin
          wpos_q <= wpos_q + 1'b1;
          tk_q   <= tk_q + 1'b1;
          if (tk_q >= 3'd3 && wpos_q[1:0] == 2'd3) st_q <= W_LEN;
        end
        W_LEN: st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
  parameter int unsigned SLOTS      = 31,
  parameter int unsigned SLOT_BYTES = 256,
  localparam int unsigned IW  = $clog2(SLOTS),
  localparam int unsigned PW  = $clog2(SLOTS + 1),
  localparam int unsigned SW  = SLOT_BYTES / 4,
  localparam int unsigned WAW = $clog2(SLOTS * SW),
  localparam int unsigned BW  = $clog2(SLOT_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_strobe,
  input  logic           fifo_rst,
  input  logic [PW-1:0]  pending,
  input  logic [31:0]    mem_word,
  input  logic [31:0]    len_word,
  output logic [WAW-1:0] rd_addr,
  output logic [WAW-1:0] len_addr,
  output logic [IW-1:0]  head,
  output logic [31:0]    rd_data,
  output logic           evt_pop
);
  import rxq_pkg::*;

  logic [BW:0] off_q;
  logic [BW:0] off_next;
  logic        have;

  assign have     = (pending != '0);
  assign rd_addr  = WAW'(word_index(32'(head), 32'(off_q), SW));
  assign len_addr = WAW'(word_index(32'(head), 0, SW));
  assign off_next = off_q + (BW+1)'(4);
  assign rd_data  = have ? mem_word : 32'd0;
  assign evt_pop  = rd_strobe && have && !fifo_rst && (32'(off_next) >= 32'(len_word[15:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      head  <= '0;
    end else if (fifo_rst) begin
      off_q <= '0;
    end else if (rd_strobe && have) begin
      if (evt_pop) begin
        off_q <= '0;
        head  <= IW'(ring_add(32'(head), 1, SLOTS));
      end else begin
        off_q <= off_next;
      end
    end
  end
endmodule

// File: rtl/rxq_frame_queue.sv
module rxq_frame_queue #(
  parameter int unsigned SLOTS      = 31,
  parameter int unsigned SLOT_BYTES = 256,
  localparam int unsigned IW  = $clog2(SLOTS),
  localparam int unsigned PW  = $clog2(SLOTS + 1),
  localparam int unsigned SW  = SLOT_BYTES / 4,
  localparam int unsigned WAW = $clog2(SLOTS * SW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          fifo_rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          rd_strobe,
  output logic [31:0]   rd_data,
  output logic [PW-1:0] pending,
  input  logic [1:0]    flag_ack,
  output logic          flag_rx,
  output logic          flag_ovf
);
  import rxq_pkg::*;

  logic           full;
  logic [IW-1:0]  head;
  logic [IW-1:0]  tail_slot;
  logic           evt_commit, evt_overrun, evt_pop;
  logic           crc_start, crc_step;
  logic [31:0]    crc_val;
  logic           wr_en;
  logic [WAW-1:0] wr_addr, rd_addr, len_addr;
  logic [3:0]     wr_be;
  logic [31:0]    wr_data, mem_word, len_word;

  assign full      = (pending == PW'(SLOTS));
  assign tail_slot = IW'(ring_add(32'(head), 32'(pending), SLOTS));

  rxq_crc u_crc (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .step(crc_step),
    .din(in_data), .crc_out(crc_val)
  );

  rxq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .full(full), .tail_slot(tail_slot),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .crc_val(crc_val), .crc_start(crc_start), .crc_step(crc_step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .evt_commit(evt_commit), .evt_overrun(evt_overrun)
  );

  rxq_store #(.DEPTH(SLOTS * SW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .be(wr_be), .wdata(wr_data),
    .raddr_a(rd_addr), .rdata_a(mem_word), .raddr_b(len_addr), .rdata_b(len_word)
  );

  rxq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .fifo_rst(fifo_rst),
    .pending(pending), .mem_word(mem_word), .len_word(len_word),
    .rd_addr(rd_addr), .len_addr(len_addr), .head(head),
    .rd_data(rd_data), .evt_pop(evt_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      flag_rx  <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      if (fifo_rst) begin
        pending <= '0;
      end else begin
        unique case ({evt_commit, evt_pop})
          2'b10:   pending <= pending + 1'b1;
          2'b01:   pending <= pending - 1'b1;
          default: pending <= pending;
        endcase
      end
      if (evt_commit)       flag_rx  <= 1'b1;
      else if (flag_ack[0]) flag_rx  <= 1'b0;
      if (evt_overrun)      flag_ovf <= 1'b1;
      else if (flag_ack[1]) flag_ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_checks.sv
module rxq_checks #(
  parameter int unsigned SLOTS = 31,
  localparam int unsigned PW   = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rst,
  input logic          rd_strobe,
  input logic [31:0]   rd_data,
  input logic [PW-1:0] pending,
  input logic          flag_rx,
  input logic          flag_ovf,
  input logic          evt_commit,
  input logic          evt_pop,
  input logic          evt_overrun
);
  AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pending) <= SLOTS); // R2
  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pending) == SLOTS) |-> !evt_commit); // R2
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |=> flag_ovf); // R3
  AST_OVF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> !evt_commit); // R3
  AST_COMMIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |=> flag_rx); // R5
  AST_COMMIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_commit && !evt_pop && !fifo_rst) |=> pending == $past(pending) + 1'b1); // R5
  AST_POP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pop && !evt_commit && !fifo_rst) |=> pending == $past(pending) - 1'b1); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && pending == '0) |-> rd_data == 32'd0); // R8
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !evt_pop); // R8
  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> pending == '0); // R9
endmodule

bind rxq_frame_queue rxq_checks #(.SLOTS(SLOTS)) u_checks (
  .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .rd_strobe(rd_strobe),
  .rd_data(rd_data), .pending(pending), .flag_rx(flag_rx), .flag_ovf(flag_ovf),
  .evt_commit(evt_commit), .evt_pop(evt_pop), .evt_overrun(evt_overrun)
);

// File: tb/rxq_frame_queue_tb_top.sv
`timescale 1ns/1ps
module rxq_frame_queue_tb_top;
  localparam int SLOTS = 31;
  localparam int SLOT_BYTES = 256;
  localparam int MAXP = SLOT_BYTES - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b1;
  logic        fifo_rst = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  pending;
  logic [1:0]  flag_ack = 2'b00;
  logic        flag_rx, flag_ovf;

  int n_checks = 0;
  int n_errs = 0;
  logic [31:0] exp_q [$];
  int          exp_words [$];
  int          exp_pend = 0;

  always #2.5 clk = ~clk;

  rxq_frame_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_rst(fifo_rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .pending(pending),
    .flag_ack(flag_ack), .flag_rx(flag_rx), .flag_ovf(flag_ovf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10: bench CRC, bit-serial with explicit feedback bit
  function automatic logic [31:0] ref_crc(logic [7:0] bytes [$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (bytes[i]) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = r[0] ^ bytes[i][k];
        r = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    end
    return ~r;
  endfunction

  // driver: sends a frame; when it is expected to be stored, pushes the R4 record image
  task automatic send_frame(int n, int seed, bit expect_store);
    logic [7:0] pl [$];
    logic [7:0] rec [$];
    logic [31:0] c;
    for (int i = 0; i < n; i++) pl.push_back(8'((seed + i * 7) & 8'hFF));
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = pl[i];
      in_last  = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (expect_store) begin
      c = ref_crc(pl);
      rec.push_back(8'((n + 6) & 8'hFF));
      rec.push_back(8'((n + 6) >> 8));
      foreach (pl[i]) rec.push_back(pl[i]);
      for (int k = 0; k < 4; k++) rec.push_back(c[8*k +: 8]);
      while (rec.size() % 4 != 0) rec.push_back(8'h00);
      for (int w = 0; w < rec.size() / 4; w++)
        exp_q.push_back({rec[4*w+3], rec[4*w+2], rec[4*w+1], rec[4*w]});
      exp_words.push_back(rec.size() / 4);
      exp_pend++;
    end
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic read_word();
    rd_strobe = 1'b1;
    @(posedge clk); #1;
    rd_strobe = 1'b0;
  endtask

  task automatic drain_one();
    int n;
    n = exp_words.pop_front();
    repeat (n) read_word();
    exp_pend--;
  endtask

  task automatic ack(logic [1:0] a);
    flag_ack = a;
    @(posedge clk); #1;
    flag_ack = 2'b00;
  endtask

  // monitor: compares each read word against the scoreboard (R6), or 0 when empty (R8)
  always @(negedge clk) begin
    if (rst_n && rd_strobe) begin
      if (exp_q.size() == 0) chk("R8 empty read data", rd_data, 32'd0);
      else chk("R6 record word", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(5.0 * 150000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("reset pending", 32'(pending), 0);
    chk("reset flag_rx", 32'(flag_rx), 0);
    chk("reset flag_ovf", 32'(flag_ovf), 0);
    chk("reset in_ready", 32'(in_ready), 1);
    @(posedge clk); #1;

    // R4 R5 R6 R10: every tail alignment
    for (int s = 1; s <= 5; s++) send_frame(s, 16 * s, 1'b1);
    chk("R5 pending after five", 32'(pending), 5);
    chk("R5 flag_rx set", 32'(flag_rx), 1);
    ack(2'b01);
    chk("R11 flag_rx cleared", 32'(flag_rx), 0);
    drain_one();
    chk("R7 pending after one drain", 32'(pending), 4);
    repeat (4) drain_one();
    chk("R7 pending drained", 32'(pending), 0);

    // R8: empty read changes nothing
    read_word();
    chk("R8 pending stays zero", 32'(pending), 0);

    // R1: disabled receive
    rx_en = 1'b0;
    send_frame(4, 3, 1'b0);
    chk("R1 pending unchanged", 32'(pending), 0);
    chk("R1 flag_rx unchanged", 32'(flag_rx), 0);
    rx_en = 1'b1;
    read_word();

    // R3: boundary sizes
    send_frame(MAXP, 5, 1'b0);
    chk("R3 overlong not stored", 32'(pending), 0);
    chk("R3 flag_ovf set", 32'(flag_ovf), 1);
    ack(2'b10);
    chk("R11 flag_ovf cleared", 32'(flag_ovf), 0);
    send_frame(MAXP - 1, 9, 1'b1);
    chk("R3 longest stored", 32'(pending), 1);
    chk("R3 no overrun on fit", 32'(flag_ovf), 0);
    drain_one();

    // R2 R7: fill all slots (ring wraps), refuse, then drain
    for (int f = 0; f < SLOTS; f++) send_frame(3, f, 1'b1);
    chk("R2 pending full", 32'(pending), SLOTS);
    in_valid = 1'b1; in_data = 8'hAA; in_last = 1'b1;
    @(negedge clk);
    chk("R2 in_ready low when full", 32'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R2 still full", 32'(pending), SLOTS);
    drain_one();
    chk("R7 pop from full", 32'(pending), SLOTS - 1);
    while (exp_words.size() > 0) drain_one();
    chk("R7 wrapped drain empty", 32'(pending), 0);

    // R9: reset mid-record
    send_frame(5, 40, 1'b1);
    send_frame(6, 50, 1'b1);
    exp_words[0] = exp_words[0] - 1;
    read_word();
    fifo_rst = 1'b1;
    @(posedge clk); #1;
    fifo_rst = 1'b0;
    exp_q.delete(); exp_words.delete(); exp_pend = 0;
    chk("R9 pending cleared", 32'(pending), 0);
    send_frame(2, 77, 1'b1);
    chk("R9 pending after refill", 32'(pending), 1);
    drain_one();
    chk("R9 drained", 32'(pending), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule